// File: doc/BRIEF.md
# Multi-mode programmable down-counter

One counting channel built around a preset-able synchronous down-counter, 16 bits wide by default. A register block outside this channel supplies the operating mode and the initial count, and pulses a strobe when each of them is written. The channel then produces one of six waveforms on its output. These are a terminal-count flag, a retriggerable one-shot, a divide-by-N rate pulse, a square wave, a strobe started by software and a strobe started by the gate. The current count is always visible on a read port.

The counter acts only on system clocks where the count-enable input is high. This enable stands for one cycle of the slower counting clock. The gate input is sampled on those same clocks. A gate rising edge is seen when the gate is high on an enabled clock and was low on the enabled clock before it. Writes act on any clock. On the clock of a write the counter does not count.

Top module: `prog_down_counter`

## Requirements
- R1: After reset, out_o is high and count_o is 0.
- R2: A control write loads the mode code on mode_i. Codes 0 to 5 select modes 0 to 5, and codes 6 and 7 act as 2 and 3. On the next clock out_o is low for code 0 and high for every other code. No count is active until a count is written.
- R3: Mode 0: a count write drives out_o low and takes effect on the next enabled clock, which loads N. Call that load tick k=0. While gate is high, each tick decrements the count, so count_o is (N-k) mod 2^16. out_o goes high at tick N and stays high. Ticks with gate low hold the count.
- R4: Mode 1: a count write leaves out_o high. A gate rising edge loads N and drives out_o low at that tick (k=0). out_o goes high at tick N. A new edge before then reloads N and extends the low time.
- R5: Mode 2: after the load tick, out_o is low for exactly one tick at every multiple of N, and the count then reloads. count_o is N-(k mod N). N must be at least 2.
- R6: Mode 3: over each period of N ticks, out_o is high for the first (N+1)/2 ticks and low for the remaining N/2 ticks. count_o is N-(k mod N).
- R7: Modes 2 and 3: with gate low, out_o is high on the next clock and the count holds. A gate rising edge reloads N and starts a new period at k=0.
- R8: Mode 4: out_o pulses low for the single tick N after the load, and only once. A new count write starts the sequence again.
- R9: Mode 5: a gate rising edge loads N (k=0), and out_o pulses low for the single tick N. A new edge before then reloads N.
- R10: An initial count of 0 acts as 65536.
- R11: While cnt_en_i is low, or on a write clock, count_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counting-clock enable (one tick) |
| gate_i | input | 1 | Gate level |
| mode_i | input | 3 | Mode code for a control write |
| count_i | input | W | Initial count for a count write |
| ctrl_wr_i | input | 1 | Control word written strobe |
| count_wr_i | input | 1 | Count written strobe |
| out_o | output | 1 | Counter output waveform |
| count_o | output | W | Current count |

## Verification
On every cycle the assertions check several properties. The output value follows a control write. Gate low forces the output high in the rate and square modes. The mode 0 flag stays high once it has risen. The strobe pulses last one tick. The count freezes on disabled and write clocks. The bench sweeps the small initial counts in every mode and compares each tick's output and count with closed-form expressions in N and k. Only these scenarios can show the waveform timing, the gate pause and reload, retrigger extension, rewrite restart and the 65536-tick terminal count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [2:0] {
    MODE_TC       = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } ctr_mode_e;

  function automatic ctr_mode_e decode_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return ctr_mode_e'({1'b0, code[1:0]});
    return ctr_mode_e'(code);
  endfunction
endpackage

// File: rtl/ctr_gate_edge.sv
module ctr_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gate_q <= 1'b0;
    else if (sample_i) gate_q <= gate_i;
  end

  assign rise_o = sample_i & gate_i & ~gate_q;
endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] init_i,
  input  logic         load_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         is_one_o,
  output logic         at_half_o
);
  localparam int EW = W + 1;

  logic [W-1:0]  count_q;
  logic [EW-1:0] n_eff, half;

  // zero count stands for 2^W
  assign n_eff = (init_i == '0) ? {1'b1, {W{1'b0}}} : {1'b0, init_i};
  assign half  = n_eff >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= init_i;
    else if (dec_i)  count_q <= count_q - 1'b1;
  end

  assign count_o   = count_q;
  assign is_one_o  = (count_q == W'(1));
  assign at_half_o = ({1'b0, count_q} == half + EW'(1));
endmodule

// File: rtl/ctr_ctl.sv
module ctr_ctl
  import ctr_pkg::*;
(
  input  ctr_mode_e mode_i,
  input  logic      tick_i,
  input  logic      gate_i,
  input  logic      rise_i,
  input  logic      pend_i,
  input  logic      have_i,
  input  logic      armed_i,
  input  logic      out_i,
  input  logic      is_one_i,
  input  logic      at_half_i,
  output logic      load_o,
  output logic      dec_o,
  output logic      out_o,
  output logic      armed_o,
  output logic      pend_clr_o
);
  logic run, trg;

  assign run = have_i & ~pend_i;
  assign trg = rise_i & have_i;

  always_comb begin
    load_o     = 1'b0;
    dec_o      = 1'b0;
    out_o      = out_i;
    armed_o    = armed_i;
    pend_clr_o = 1'b0;
    if (tick_i) begin
      case (mode_i)
        MODE_TC: begin
          if (pend_i) begin
            load_o = 1'b1; pend_clr_o = 1'b1;
          end else if (run && gate_i) begin
            dec_o = 1'b1;
            if (is_one_i) out_o = 1'b1;
          end
        end
        MODE_ONESHOT: begin
          if (trg) begin
            load_o = 1'b1; out_o = 1'b0; armed_o = 1'b1;
          end else begin
            dec_o = 1'b1;
            if (is_one_i && armed_i) begin
              out_o = 1'b1; armed_o = 1'b0;
            end
          end
        end
        MODE_RATE: begin
          out_o = 1'b1;
          if (pend_i || trg) begin
            load_o = 1'b1; pend_clr_o = 1'b1;
          end else if (run && gate_i) begin
            if (is_one_i) begin
              load_o = 1'b1; out_o = 1'b0;
            end else dec_o = 1'b1;
          end
        end
        MODE_SQUARE: begin
          if (pend_i || trg) begin
            load_o = 1'b1; pend_clr_o = 1'b1; out_o = 1'b1;
          end else if (run && gate_i) begin
            if (is_one_i) begin
              load_o = 1'b1; out_o = 1'b1;
            end else begin
              dec_o = 1'b1;
              if (at_half_i) out_o = 1'b0;
            end
          end
        end
        MODE_SWSTROBE: begin
          out_o = 1'b1;
          if (pend_i) begin
            load_o = 1'b1; pend_clr_o = 1'b1; armed_o = 1'b1;
          end else if (run && gate_i) begin
            dec_o = 1'b1;
            if (is_one_i && armed_i) begin
              out_o = 1'b0; armed_o = 1'b0;
            end
          end
        end
        MODE_HWSTROBE: begin
          out_o = 1'b1;
          if (trg) begin
            load_o = 1'b1; armed_o = 1'b1;
          end else begin
            dec_o = 1'b1;
            if (is_one_i && armed_i) begin
              out_o = 1'b0; armed_o = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
    // gate low forces high in periodic modes, enabled or not
    if ((mode_i == MODE_RATE || mode_i == MODE_SQUARE) && !gate_i) out_o = 1'b1;
  end
endmodule

// File: rtl/prog_down_counter.sv
module prog_down_counter
  import ctr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         gate_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] count_i,
  input  logic         ctrl_wr_i,
  input  logic         count_wr_i,
  output logic         out_o,
  output logic [W-1:0] count_o
);
  ctr_mode_e    mode_q;
  logic [W-1:0] init_q;
  logic         out_q, armed_q, pend_q, have_q;
  logic         tick, rise, load, dec, is_one, at_half;
  logic         out_nxt, armed_nxt, pend_clr;

  assign tick = cnt_en_i & ~ctrl_wr_i & ~count_wr_i;

  ctr_gate_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(cnt_en_i),
    .gate_i  (gate_i),
    .rise_o  (rise)
  );

  ctr_ctl u_ctl (
    .mode_i    (mode_q),
    .tick_i    (tick),
    .gate_i    (gate_i),
    .rise_i    (rise),
    .pend_i    (pend_q),
    .have_i    (have_q),
    .armed_i   (armed_q),
    .out_i     (out_q),
    .is_one_i  (is_one),
    .at_half_i (at_half),
    .load_o    (load),
    .dec_o     (dec),
    .out_o     (out_nxt),
    .armed_o   (armed_nxt),
    .pend_clr_o(pend_clr)
  );

  ctr_datapath #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_q),
    .load_i   (load),
    .dec_i    (dec),
    .count_o  (count_o),
    .is_one_o (is_one),
    .at_half_o(at_half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_TC;
      init_q  <= '0;
      out_q   <= 1'b1;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (ctrl_wr_i) begin
      mode_q  <= decode_mode(mode_i);
      out_q   <= (mode_i != 3'd0);
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (count_wr_i) begin
      init_q <= count_i;
      pend_q <= 1'b1;
      have_q <= 1'b1;
      if (mode_q == MODE_TC) out_q <= 1'b0;
    end else begin
      out_q   <= out_nxt;
      armed_q <= armed_nxt;
      if (pend_clr) pend_q <= 1'b0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/ctr_chk.sv
module ctr_chk
  import ctr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         gate_i,
  input logic [2:0]   mode_i,
  input logic         ctrl_wr_i,
  input logic         count_wr_i,
  input ctr_mode_e    mode_q,
  input logic         out_o,
  input logic [W-1:0] count_o
);
  logic no_wr;
  assign no_wr = !ctrl_wr_i && !count_wr_i;

  // R2
  ctrl_out_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (out_o == ($past(mode_i) != 3'd0)));

  // R3
  tc_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TC && out_o && no_wr) |=> out_o);

  // R5
  rate_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RATE && !out_o && cnt_en_i && no_wr) |=> out_o);

  // R7
  gate_low_forces_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_RATE || mode_q == MODE_SQUARE) && !gate_i && no_wr) |=> out_o);

  // R8 R9
  strobe_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_SWSTROBE || mode_q == MODE_HWSTROBE) && !out_o && cnt_en_i && no_wr)
    |=> out_o);

  // R11
  count_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i || !no_wr) |=> $stable(count_o));
endmodule

bind prog_down_counter ctr_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_en_i  (cnt_en_i),
  .gate_i    (gate_i),
  .mode_i    (mode_i),
  .ctrl_wr_i (ctrl_wr_i),
  .count_wr_i(count_wr_i),
  .mode_q    (mode_q),
  .out_o     (out_o),
  .count_o   (count_o)
);

// File: tb/tb_prog_down_counter.sv
module tb_prog_down_counter;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b1;
  logic         gate = 1'b1;
  logic [2:0]   mode = '0;
  logic [W-1:0] count_in = '0;
  logic         ctrl_wr = 1'b0;
  logic         count_wr = 1'b0;
  logic         out;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prog_down_counter #(.W(W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cnt_en_i  (cnt_en),
    .gate_i    (gate),
    .mode_i    (mode),
    .count_i   (count_in),
    .ctrl_wr_i (ctrl_wr),
    .count_wr_i(count_wr),
    .out_o     (out),
    .count_o   (count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr_ctrl(input int m);
    ctrl_wr = 1'b1; mode = 3'(m);
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_count(input int n);
    count_wr = 1'b1; count_in = W'(n);
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  function automatic int neff(input int n);
    return (n == 0) ? 65536 : n;
  endfunction

  function automatic int exp_out(input int m, input int n, input int k);
    int e = neff(n);
    case (m)
      0: return (k >= e) ? 1 : 0;
      1: return (k >= e) ? 1 : 0;
      2: return (k > 0 && k % e == 0) ? 0 : 1;
      3: return ((k % e) < (e + 1) / 2) ? 1 : 0;
      default: return (k == e) ? 0 : 1;
    endcase
  endfunction

  function automatic int exp_cnt(input int m, input int n, input int k);
    int e = neff(n);
    if (m == 2 || m == 3) return (e - (k % e)) & 16'hFFFF;
    return (e - k) & 16'hFFFF;
  endfunction

  task automatic sweep(input string req, input int m, input int n, input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      @(negedge clk);
      chk(req, int'(out), exp_out(m, n, k));
      chk(req, int'(count), exp_cnt(m, n, k));
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 out", int'(out), 1);
    chk("R1 count", int'(count), 0);
    idle(1);

    // R2 R3 mode 0 terminal count, several N
    for (int n = 1; n <= 6; n++) begin
      wr_ctrl(0);
      chk("R2 mode0 out low", int'(out), 0);
      wr_count(n);
      sweep("R3", 0, n, 0, n + 3);
    end
    // R3 gate pause
    wr_ctrl(0);
    wr_count(6);
    sweep("R3 pre-pause", 0, 6, 0, 2);
    gate = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R3 paused count", int'(count), 4);
      chk("R3 paused out", int'(out), 0);
    end
    gate = 1'b1;
    sweep("R3 resumed", 0, 6, 3, 8);

    // R5 rate generator sweep, plus code 6 alias
    for (int n = 2; n <= 7; n++) begin
      wr_ctrl(2);
      chk("R2 mode2 out high", int'(out), 1);
      wr_count(n);
      sweep("R5", 2, n, 0, 3 * n);
    end
    wr_ctrl(6);
    wr_count(3);
    sweep("R5 code6", 2, 3, 0, 9);

    // R6 square wave sweep, plus code 7 alias
    for (int n = 2; n <= 9; n++) begin
      wr_ctrl(3);
      wr_count(n);
      sweep("R6", 3, n, 0, 3 * n);
    end
    wr_ctrl(7);
    wr_count(5);
    sweep("R6 code7", 3, 5, 0, 10);

    // R7 mode 3: gate low in low phase forces high, edge reloads
    wr_ctrl(3);
    wr_count(6);
    sweep("R7 pre", 3, 6, 0, 4);
    gate = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R7 forced out", int'(out), 1);
      chk("R7 held count", int'(count), 2);
    end
    gate = 1'b1;
    sweep("R7 reload", 3, 6, 0, 12);
    // R7 mode 2 mid-count reload
    wr_ctrl(2);
    wr_count(5);
    sweep("R7 m2 pre", 2, 5, 0, 2);
    gate = 1'b0;
    @(negedge clk);
    chk("R7 m2 held", int'(count), 3);
    gate = 1'b1;
    sweep("R7 m2 reload", 2, 5, 0, 10);

    // R11 enable low freezes
    wr_ctrl(2);
    wr_count(5);
    sweep("R11 pre", 2, 5, 0, 2);
    cnt_en = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R11 frozen count", int'(count), 3);
      chk("R11 frozen out", int'(out), 1);
    end
    cnt_en = 1'b1;
    sweep("R11 resumed", 2, 5, 3, 12);

    // R8 software strobe, single pulse and rewrite restart
    for (int n = 1; n <= 5; n++) begin
      wr_ctrl(4);
      wr_count(n);
      sweep("R8", 4, n, 0, n + 4);
    end
    wr_ctrl(4);
    wr_count(4);
    sweep("R8 first", 4, 4, 0, 7);
    wr_count(3);
    sweep("R8 rewrite", 4, 3, 0, 6);

    // R4 one-shot
    gate = 1'b0;
    idle(2);
    for (int n = 1; n <= 5; n++) begin
      wr_ctrl(1);
      wr_count(n);
      chk("R4 out high after count write", int'(out), 1);
      idle(2);
      gate = 1'b1;
      sweep("R4", 1, n, 0, n + 2);
      gate = 1'b0;
      idle(2);
    end
    // R4 retrigger
    wr_ctrl(1);
    wr_count(4);
    idle(2);
    gate = 1'b1;
    sweep("R4 trig", 1, 4, 0, 0);
    gate = 1'b0;
    sweep("R4 mid", 1, 4, 1, 1);
    gate = 1'b1;
    sweep("R4 retrig", 1, 4, 0, 6);
    gate = 1'b0;
    idle(2);

    // R9 hardware strobe
    for (int n = 1; n <= 5; n++) begin
      wr_ctrl(5);
      wr_count(n);
      idle(2);
      chk("R9 idle out", int'(out), 1);
      gate = 1'b1;
      sweep("R9", 5, n, 0, n + 2);
      gate = 1'b0;
      idle(2);
    end
    wr_ctrl(5);
    wr_count(4);
    idle(2);
    gate = 1'b1;
    sweep("R9 trig", 5, 4, 0, 0);
    gate = 1'b0;
    sweep("R9 mid", 5, 4, 1, 1);
    gate = 1'b1;
    sweep("R9 retrig", 5, 4, 0, 6);
    idle(2);

    // R10 zero count acts as 65536
    wr_ctrl(0);
    wr_count(0);
    sweep("R10 load", 0, 0, 0, 0);
    idle(65534);
    sweep("R10 terminal", 0, 0, 65535, 65536);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule